// File: doc/BRIEF.md
# Deferrable Manual Row-Refresh Scheduler

This block keeps DRAM contents alive without the device's own refresh command. It places ordinary row activate accesses, closed by auto-precharge, into the scheduler slots that a memory resource already owns. Each resource holds two banks. For each resource the block keeps its own row counter and bank-select bit. The row counter sweeps every row of one bank and then moves on to the other bank.

A shared round timer counts scheduler rounds. Every N-th round it makes one refresh due on every resource. N is 60 at burst length 4 and 39 at burst length 8. A due refresh is owed until a slot of that resource can take it:
- A pipeline load that arrives in the same slot wins, and the refresh moves to the next slot.
- While a bulk transfer owns the resource, a single owed refresh is held back. It is then issued in the first slot after the transfer ends.
- If a second refresh falls due during the transfer, the refresh claims the slot and the transfer waits.

A per-resource count of owed refreshes raises a sticky error flag once it passes its bound.

Top module: `mrefresh_sched`

## Requirements
- R1: After reset every grant and error output is 0, and every resource addresses row 0 of bank 0.
- R2: With `burst8`=0 a refresh falls due on the 60th `round_tick` after reset and then on every 60th one. With `burst8`=1 the spacing is 39 ticks, counted from the previous due point.
- R3: In a slot (`slot_tick[r]`=1) with a refresh owed, no load and no transfer, `ref_grant[r]` is 1 in that cycle, and that owed refresh is then cleared.
- R4: When `load_req[r]` is 1 in a slot, `ref_grant[r]` is 0 in that slot. The owed refresh is granted in the next slot of the resource that has no load.
- R5: While `dma_busy[r]` is 1 and exactly one refresh is owed, no grant is given. That refresh is granted in the first slot with `dma_busy[r]`=0.
- R6: While `dma_busy[r]` is 1 and two or more refreshes are owed, the slot is granted to refresh.
- R7: A grant addresses the current `ref_row`/`ref_bank` pair of that resource, and the next grant addresses the next row. After row ROWS-1 the row returns to 0 and the bank bit toggles. The k-th grant (k counted from 0) addresses row k mod ROWS and bank (k div ROWS) mod 2.
- R8: When a refresh falls due while OWED_MAX (default 3) refreshes are already owed, `owed_err[r]` becomes 1. It stays 1 until reset, and other resources are not affected.
- R9: `ref_grant[r]` is never 1 in a cycle where `slot_tick[r]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| round_tick | input | 1 | One pulse per scheduler round |
| burst8 | input | 1 | 1 selects the burst-length-8 refresh spacing |
| slot_tick | input | NUM_RES | Slot of resource r is in this cycle |
| load_req | input | NUM_RES | A pipeline load claims resource r's slot |
| dma_busy | input | NUM_RES | A bulk transfer owns resource r |
| ref_grant | output | NUM_RES | This slot carries a refresh access |
| ref_bank | output | NUM_RES | Bank select for the refresh of resource r |
| ref_row | output | NUM_RES*ROW_W | Row for the refresh of resource r (resource r at bits r*ROW_W upward) |
| owed_err | output | NUM_RES | Sticky: too many refreshes owed |

## Verification
The bench first runs quiet rounds, so the only thing it observes is the due spacing at both burst settings and the row/bank address of each grant. It then places a load exactly on a due slot, to tell "deferred by one slot" apart from "dropped". It runs a short transfer and a long transfer across a due point, which tells the single held refresh apart from the second due refresh that must take the slot. Finally it sends loads in every slot of one resource until the owed count passes its bound, and checks that the error flag stays on that resource alone.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE    = 2'd0,
    SLOT_LOAD    = 2'd1,
    SLOT_XFER    = 2'd2,
    SLOT_REFRESH = 2'd3
  } slot_use_e;
endpackage

// File: rtl/rfs_round_timer.sv
module rfs_round_timer #(
  parameter int unsigned INTV_BL4 = 60,
  parameter int unsigned INTV_BL8 = 39
) (
  input  logic clk,
  input  logic rst_n,
  input  logic round_tick,
  input  logic burst8,
  output logic due
);
  localparam int unsigned IMAX = (INTV_BL4 > INTV_BL8) ? INTV_BL4 : INTV_BL8;
  localparam int unsigned CW   = $clog2(IMAX + 1);

  logic [CW-1:0] cnt_q, cnt_d, last;
  logic          at_end;

  always_comb begin
    last   = burst8 ? CW'(INTV_BL8 - 1) : CW'(INTV_BL4 - 1);
    at_end = (cnt_q >= last);
    due    = round_tick && at_end;
    cnt_d  = cnt_q;
    if (round_tick) cnt_d = at_end ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (round_tick) cnt_q <= cnt_d;
  end

  // due only on a tick, spacing restarts from zero
  p_due_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    due |=> (cnt_q == '0));
endmodule

// File: rtl/rfs_row_sweep.sv
module rfs_row_sweep #(
  parameter int unsigned ROWS = 8192
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  output logic [$clog2(ROWS)-1:0]  row,
  output logic                     bank
);
  localparam int unsigned RW = $clog2(ROWS);

  logic [RW-1:0] row_q, row_d;
  logic          bank_q, bank_d;
  logic          wrap;

  always_comb begin
    wrap   = (row_q == RW'(ROWS - 1));
    row_d  = wrap ? '0 : row_q + RW'(1);
    bank_d = wrap ? ~bank_q : bank_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q  <= '0;
      bank_q <= 1'b0;
    end else if (adv) begin
      row_q  <= row_d;
      bank_q <= bank_d;
    end
  end

  assign row  = row_q;
  assign bank = bank_q;

  p_row_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && row_q != RW'(ROWS - 1)) |=> (row_q == $past(row_q) + RW'(1)) && $stable(bank_q));
  p_bank_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && row_q == RW'(ROWS - 1)) |=> (row_q == '0) && (bank_q != $past(bank_q)));
endmodule

// File: rtl/rfs_owed_track.sv
module rfs_owed_track
  import rfs_pkg::*;
#(
  parameter int unsigned OWED_MAX     = 3,
  parameter int unsigned DEADLINE_CYC = 20000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic due,
  input  logic slot,
  input  logic load,
  input  logic dma,
  output logic grant,
  output logic err
);
  localparam int unsigned CW = $clog2(OWED_MAX + 2);
  localparam int unsigned AW = $clog2(DEADLINE_CYC + 2);

  logic [CW-1:0] owed_q, owed_d;
  logic [AW-1:0] age_q, age_d;
  logic          err_q, err_d;
  logic          sat;
  slot_use_e     use_s;

  always_comb begin
    use_s = SLOT_IDLE;
    if (slot) begin
      if (load)                                           use_s = SLOT_LOAD;
      else if (owed_q != '0 && (!dma || owed_q >= CW'(2))) use_s = SLOT_REFRESH;
      else if (dma)                                       use_s = SLOT_XFER;
    end
    grant  = (use_s == SLOT_REFRESH);
    sat    = (owed_q == CW'(OWED_MAX + 1));
    owed_d = owed_q + CW'(due && !sat) - CW'(grant);
    err_d  = err_q | (due && owed_q >= CW'(OWED_MAX));
    if (grant || owed_q == '0)             age_d = '0;
    else if (age_q != AW'(DEADLINE_CYC + 1)) age_d = age_q + AW'(1);
    else                                   age_d = age_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owed_q <= '0;
      err_q  <= 1'b0;
      age_q  <= '0;
    end else begin
      owed_q <= owed_d;
      err_q  <= err_d;
      age_q  <= age_d;
    end
  end

  assign err = err_q;

  p_grant_in_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> slot);
  p_load_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && load) |-> !grant);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  p_owed_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !err_q |-> (owed_q <= CW'(OWED_MAX)));
  p_defer_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n || err_q)
    age_q <= AW'(DEADLINE_CYC));
endmodule

// File: rtl/mrefresh_sched.sv
module mrefresh_sched #(
  parameter int unsigned NUM_RES      = 4,
  parameter int unsigned ROWS         = 8192,
  parameter int unsigned INTV_BL4     = 60,
  parameter int unsigned INTV_BL8     = 39,
  parameter int unsigned OWED_MAX     = 3,
  parameter int unsigned DEADLINE_CYC = 20000,
  localparam int unsigned ROW_W       = $clog2(ROWS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     round_tick,
  input  logic                     burst8,
  input  logic [NUM_RES-1:0]       slot_tick,
  input  logic [NUM_RES-1:0]       load_req,
  input  logic [NUM_RES-1:0]       dma_busy,
  output logic [NUM_RES-1:0]       ref_grant,
  output logic [NUM_RES-1:0]       ref_bank,
  output logic [NUM_RES*ROW_W-1:0] ref_row,
  output logic [NUM_RES-1:0]       owed_err
);
  logic due;

  rfs_round_timer #(.INTV_BL4(INTV_BL4), .INTV_BL8(INTV_BL8)) u_timer (
    .clk(clk), .rst_n(rst_n), .round_tick(round_tick), .burst8(burst8), .due(due)
  );

  for (genvar r = 0; r < NUM_RES; r++) begin : g_res
    logic gnt;

    rfs_owed_track #(.OWED_MAX(OWED_MAX), .DEADLINE_CYC(DEADLINE_CYC)) u_owed (
      .clk(clk), .rst_n(rst_n), .due(due), .slot(slot_tick[r]),
      .load(load_req[r]), .dma(dma_busy[r]), .grant(gnt), .err(owed_err[r])
    );

    rfs_row_sweep #(.ROWS(ROWS)) u_sweep (
      .clk(clk), .rst_n(rst_n), .adv(gnt),
      .row(ref_row[r*ROW_W +: ROW_W]), .bank(ref_bank[r])
    );

    assign ref_grant[r] = gnt;
  end
endmodule

// File: tb/mrefresh_sched_bench.sv
module mrefresh_sched_bench;
  localparam int NR   = 2;
  localparam int ROWS = 4;
  localparam int RW   = $clog2(ROWS);

  logic clk = 1'b0;
  logic rst_n, round_tick, burst8;
  logic [NR-1:0] slot_tick, load_req, dma_busy, ref_grant, ref_bank, owed_err;
  logic [NR*RW-1:0] ref_row;

  int checks = 0, failures = 0;
  int gcount [NR];

  always #4 clk = ~clk;

  mrefresh_sched #(.NUM_RES(NR), .ROWS(ROWS)) u_mrefresh_sched (
    .clk(clk), .rst_n(rst_n), .round_tick(round_tick), .burst8(burst8),
    .slot_tick(slot_tick), .load_req(load_req), .dma_busy(dma_busy),
    .ref_grant(ref_grant), .ref_bank(ref_bank), .ref_row(ref_row), .owed_err(owed_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one 13-cycle round: tick, one slot per resource, idle cycles
  task automatic do_round(input logic [NR-1:0] ld, input logic [NR-1:0] dm,
                          input logic [NR-1:0] exp_g, input string req);
    logic [NR-1:0] g;
    g = '0;
    @(negedge clk); dma_busy = dm; round_tick = 1'b1;
    @(negedge clk); round_tick = 1'b0;
    for (int r = 0; r < NR; r++) begin
      slot_tick[r] = 1'b1; load_req[r] = ld[r];
      #1;
      g[r] = ref_grant[r];
      if (g[r]) begin
        // R7: k-th grant addresses row k mod ROWS, bank (k div ROWS) mod 2
        chk(ref_row[r*RW +: RW] == RW'(gcount[r] % ROWS), "R7 row",
            int'(ref_row[r*RW +: RW]), gcount[r] % ROWS);
        chk(ref_bank[r] == 1'((gcount[r] / ROWS) % 2), "R7 bank",
            int'(ref_bank[r]), (gcount[r] / ROWS) % 2);
        gcount[r]++;
      end
      @(negedge clk); slot_tick = '0; load_req = '0;
    end
    repeat (13 - 2 - NR) @(negedge clk);
    chk(g == exp_g, req, int'(g), int'(exp_g));
  endtask

  task automatic run_rounds(input int n, input logic [NR-1:0] ld, input logic [NR-1:0] dm,
                            input logic [NR-1:0] exp_g, input string req);
    for (int i = 0; i < n; i++) do_round(ld, dm, exp_g, req);
  endtask

  task automatic t_reset;
    #1;
    chk(ref_grant == '0, "R1 grant", int'(ref_grant), 0);
    chk(owed_err == '0, "R1 err", int'(owed_err), 0);
    chk(ref_row == '0 && ref_bank == '0, "R1 address", int'(ref_row), 0);
  endtask

  task automatic t_spacing_bl4;
    run_rounds(59, '0, '0, 2'b00, "R2 quiet bl4");
    run_rounds(1,  '0, '0, 2'b11, "R3 grant on due bl4");
    run_rounds(59, '0, '0, 2'b00, "R2 quiet bl4 second");
    run_rounds(1,  '0, '0, 2'b11, "R2 second due bl4");
  endtask

  task automatic t_spacing_bl8;
    burst8 = 1'b1;
    run_rounds(38, '0, '0, 2'b00, "R2 quiet bl8");
    run_rounds(1,  '0, '0, 2'b11, "R2 due bl8");
  endtask

  task automatic t_load_defer;
    run_rounds(38, '0, '0, 2'b00, "R4 lead-in");
    run_rounds(1, 2'b01, '0, 2'b10, "R4 load wins slot");
    run_rounds(1, '0, '0, 2'b01, "R4 refresh in next slot");
  endtask

  task automatic t_dma_short;
    run_rounds(37, '0, '0, 2'b00, "R5 lead-in");
    run_rounds(1, '0, 2'b01, 2'b10, "R5 held during transfer");
    run_rounds(2, '0, 2'b01, 2'b00, "R5 still held");
    run_rounds(1, '0, '0, 2'b01, "R5 compensating refresh");
  endtask

  task automatic t_dma_long;
    run_rounds(35, '0, '0, 2'b00, "R6 lead-in");
    run_rounds(1, '0, 2'b01, 2'b10, "R5 first due held");
    run_rounds(38, '0, 2'b01, 2'b00, "R5 held long");
    run_rounds(1, '0, 2'b01, 2'b11, "R6 second due takes slot");
    run_rounds(1, '0, 2'b01, 2'b00, "R6 one still held");
    run_rounds(1, '0, '0, 2'b01, "R5 compensating after long");
  endtask

  task automatic t_overflow;
    run_rounds(36, 2'b10, '0, 2'b00, "R8 lead-in");
    for (int d = 1; d <= 4; d++) begin
      if (d > 1) run_rounds(38, 2'b10, '0, 2'b00, "R8 starve");
      run_rounds(1, 2'b10, '0, 2'b01, "R8 due while starved");
      chk(owed_err == ((d == 4) ? 2'b10 : 2'b00), "R8 error flag",
          int'(owed_err), (d == 4) ? 2 : 0);
    end
    // R9: refresh owed on resource 1, but no slot this cycle
    @(negedge clk); #1;
    chk(ref_grant == '0, "R9 no grant outside slot", int'(ref_grant), 0);
    run_rounds(1, '0, '0, 2'b10, "R3 owed refresh drains");
    chk(owed_err == 2'b10, "R8 sticky", int'(owed_err), 2);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) gcount[r] = 0;
    rst_n = 1'b0; round_tick = 1'b0; burst8 = 1'b0;
    slot_tick = '0; load_req = '0; dma_busy = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_spacing_bl4();
    t_spacing_bl8();
    t_load_defer();
    t_dma_short();
    t_dma_long();
    t_overflow();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule